// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus master and a byte-addressable memory port. It serves two alias windows in which every 32-bit alias word stands for a single bit of a backing region. Reading an alias word fetches the backing unit (byte, halfword or word, as the request size says) and returns the chosen bit as 0 or 1. Writing an alias word runs a read-modify-write that changes only that bit.

The read-modify-write is atomic at the slave port. From acceptance until the response, the bridge holds its request-ready low, so no other request can slip in between the read and the write-back. A request whose address lies in neither window is not claimed. For such a request the miss output rises so that a neighbouring decoder can route it elsewhere.

Top module: `bitband_bridge`

## Requirements
- R1: Alias window 0 covers 0x22000000 to 0x23FFFFFF and maps onto region base 0x20000000. Window 1 covers 0x42000000 to 0x43FFFFFF and maps onto 0x40000000. For a request outside both windows, req_miss is 1, req_ready is 0 and no memory request is issued.
- R2: The backing byte address is the region base ORed with (alias address bits [24:0]) shifted right by 5. It is then aligned to the access size and presented on mem_addr.
- R3: When req_size is 0 (byte), the bit index is alias bits [4:2]. mem_addr is the unaligned byte address, and mem_be has the single lane mem_addr[1:0] set.
- R4: When req_size is 1 (halfword), the bit index is alias bits [5:2] and mem_addr bit 0 is cleared. mem_be is 4'b0011 or 4'b1100, selected by mem_addr[1].
- R5: When req_size is 2 or 3 (word), the bit index is alias bits [6:2], mem_addr bits [1:0] are cleared and mem_be is 4'b1111.
- R6: An alias read returns rsp_rdata bit 0 equal to the selected backing bit, with all other bits 0. The result is valid for one cycle with rsp_valid. Memory data lanes are little-endian: lane k carries the byte at address offset k.
- R7: An alias write reads the backing unit first. It then writes the unit back with the selected bit equal to req_wdata bit 0 and every other bit unchanged, enabling only the lanes of the unit.
- R8: Only one access is in progress at a time, and req_ready stays 0 from acceptance until rsp_valid. With a memory that accepts at once and returns read data one cycle after acceptance, rsp_valid rises 3 cycles after acceptance for a read and 4 cycles after for a write.
- R9: Synchronous reset returns the bridge to idle. No memory request or response is outstanding after reset.
- R10: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr, mem_be and mem_write hold their values. Stalled accesses still complete with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Slave request valid |
| req_ready | output | 1 | Slave request accepted when high together with req_valid |
| req_miss | output | 1 | Request valid but outside both alias windows |
| req_addr | input | 32 | Alias byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read result (0 or 1); zero for writes |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Aligned backing address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data on little-endian lanes |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
With the bench memory accepting at once and answering a read on the cycle after acceptance, a read response is due 3 cycles after the acceptance edge and a write response 4 cycles after it. The access task counts falling edges from the acceptance edge and checks rsp_valid at exactly that count. It also checks req_ready one falling edge after acceptance, to confirm the port is closed. Memory address, lane enables and written word contents are compared at the falling edge after the response, when the memory model has recorded them. Miss decoding is sampled right after the inputs change, because req_miss and req_ready are combinational.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_DONE    = 3'd4
  } rmw_state_e;
endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_BITS = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000},
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [ADDR_W-1:0] back_addr,
  output logic [POS_W-1:0]  bit_pos,
  output logic [LANES-1:0]  be
);
  import bb_pkg::*;

  logic [NUM_WIN-1:0] match;
  logic [ADDR_W-1:0]  region;
  logic [ADDR_W-1:0]  back_raw;
  logic [ADDR_W-1:0]  align_mask;
  logic [1:0]         unit_lg;
  logic [POS_W-1:0]   idx;
  logic [LANES-1:0]   be_base;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] ABASE = ALIAS_BASES[w*ADDR_W +: ADDR_W];
    assign match[w] = (addr[ADDR_W-1:SPAN_BITS] == ABASE[ADDR_W-1:SPAN_BITS]);
  end

  always_comb begin
    region = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (match[w]) region = region | BACK_BASES[w*ADDR_W +: ADDR_W];
    end
  end

  assign hit      = |match;
  assign back_raw = region |
                    ({{(ADDR_W-SPAN_BITS){1'b0}}, addr[SPAN_BITS-1:0]} >> 5);

  always_comb begin
    unit_lg = 2'd2;
    idx     = addr[POS_W+1:2];
    if (size == SZ_BYTE) begin
      unit_lg = 2'd0;
      idx     = POS_W'(addr[4:2]);
    end else if (size == SZ_HALF) begin
      unit_lg = 2'd1;
      idx     = POS_W'(addr[5:2]);
    end
  end

  assign align_mask = (ADDR_W'(1) << unit_lg) - ADDR_W'(1);
  assign back_addr  = back_raw & ~align_mask;
  assign bit_pos    = POS_W'({back_addr[LANE_W-1:0], 3'b000}) + idx;
  assign be_base    = LANES'((32'd1 << (32'd1 << unit_lg)) - 32'd1);
  assign be         = be_base << back_addr[LANE_W-1:0];
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [POS_W-1:0]  pos,
  input  logic              new_bit,
  output logic              bit_out,
  output logic [DATA_W-1:0] word_out
);
  logic [DATA_W-1:0] sel;

  assign sel      = DATA_W'(1) << pos;
  assign bit_out  = |(word_in & sel);
  assign word_out = new_bit ? (word_in | sel) : (word_in & ~sel);
endmodule

// File: rtl/bb_rmw_fsm.sv
module bb_rmw_fsm #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_hit,
  input  logic              req_write,
  input  logic              req_bit,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [POS_W-1:0]  dec_pos,
  input  logic [LANES-1:0]  dec_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  import bb_pkg::*;

  rmw_state_e        state_q;
  logic [POS_W-1:0]  pos_q;
  logic              wr_q;
  logic              bit_q;
  logic              mem_valid_q;
  logic              mem_write_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [LANES-1:0]  mem_be_q;
  logic [DATA_W-1:0] mem_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              lane_bit;
  logic [DATA_W-1:0] lane_word;

  bb_bit_lane #(.DATA_W(DATA_W)) u_lane (
    .word_in  (mem_rdata),
    .pos      (pos_q),
    .new_bit  (bit_q),
    .bit_out  (lane_bit),
    .word_out (lane_word)
  );

  assign req_ready = (state_q == ST_IDLE) && req_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pos_q       <= '0;
      wr_q        <= 1'b0;
      bit_q       <= 1'b0;
      mem_valid_q <= 1'b0;
      mem_write_q <= 1'b0;
      mem_addr_q  <= '0;
      mem_be_q    <= '0;
      mem_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          rsp_valid_q <= 1'b0;
          if (req_valid && req_ready) begin
            pos_q       <= dec_pos;
            wr_q        <= req_write;
            bit_q       <= req_bit;
            mem_addr_q  <= dec_addr;
            mem_be_q    <= dec_be;
            mem_write_q <= 1'b0;
            mem_valid_q <= 1'b1;
            state_q     <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (mem_ready) begin
            mem_valid_q <= 1'b0;
            state_q     <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (mem_rvalid) begin
            if (wr_q) begin
              mem_wdata_q <= lane_word;
              mem_write_q <= 1'b1;
              mem_valid_q <= 1'b1;
              state_q     <= ST_WR_REQ;
            end else begin
              rsp_rdata_q <= DATA_W'(lane_bit);
              rsp_valid_q <= 1'b1;
              state_q     <= ST_DONE;
            end
          end
        end
        ST_WR_REQ: begin
          if (mem_ready) begin
            mem_valid_q <= 1'b0;
            mem_write_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_valid_q <= 1'b1;
            state_q     <= ST_DONE;
          end
        end
        ST_DONE: begin
          rsp_valid_q <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = mem_valid_q;
  assign mem_write = mem_write_q;
  assign mem_addr  = mem_addr_q;
  assign mem_be    = mem_be_q;
  assign mem_wdata = mem_wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  AST_RSP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> (rsp_rdata_q[DATA_W-1:1] == '0)); // R6

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_q && !mem_ready) |=> (mem_valid_q && $stable(mem_addr_q) &&
                                     $stable(mem_be_q) && $stable(mem_write_q))); // R10

  AST_PORT_CLOSED_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_valid_q && !rsp_valid_q)); // R8

  AST_HALF_LANE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_q && $countones(mem_be_q) == 2) |->
      ((mem_be_q == 4'b0011 || mem_be_q == 4'b1100) && !mem_addr_q[0])); // R4

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_q && mem_be_q == 4'b1111) |-> (mem_addr_q[1:0] == 2'b00)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mem_valid_q && !rsp_valid_q)); // R9
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_BITS = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000},
  localparam int LANES = DATA_W / 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_miss,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              hit;
  logic [ADDR_W-1:0] dec_addr;
  logic [POS_W-1:0]  dec_pos;
  logic [LANES-1:0]  dec_be;

  bb_window_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .SPAN_BITS(SPAN_BITS),
    .ALIAS_BASES(ALIAS_BASES), .BACK_BASES(BACK_BASES)
  ) u_decode (
    .addr      (req_addr),
    .size      (req_size),
    .hit       (hit),
    .back_addr (dec_addr),
    .bit_pos   (dec_pos),
    .be        (dec_be)
  );

  bb_rmw_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_hit    (hit),
    .req_write  (req_write),
    .req_bit    (req_wdata[0]),
    .dec_addr   (dec_addr),
    .dec_pos    (dec_pos),
    .dec_be     (dec_be),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  assign req_miss = req_valid && !hit;

  AST_MISS_NEVER_READY: assert property (@(posedge clk) disable iff (rst)
    req_miss |-> !req_ready); // R1

  AST_MISS_NO_MEM_START: assert property (@(posedge clk) disable iff (rst)
    (req_miss && !mem_valid && !rsp_valid) |=> !mem_valid); // R1
endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready, req_miss;
  logic [31:0] req_addr = 32'h0;
  logic [1:0]  req_size = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = 32'h0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mem  [0:63];
  logic [31:0] refm [0:63];
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [3:0]  last_rd_be, last_wr_be;
  logic        stall_en = 1'b0;
  logic [1:0]  cyc = 2'd0;

  always #2 clk = ~clk;

  bitband_bridge u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_miss(req_miss), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int midx(logic [31:0] a);
    return {26'd0, a[30], a[6:2]};
  endfunction

  assign mem_ready = stall_en ? (cyc == 2'b11) : 1'b1;

  always @(posedge clk) begin
    cyc        <= cyc + 2'd1;
    mem_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
    end else if (mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[midx(mem_addr)][l*8 +: 8] <= mem_wdata[l*8 +: 8];
        last_wr_addr <= mem_addr;
        last_wr_be   <= mem_be;
      end else begin
        mem_rvalid   <= 1'b1;
        mem_rdata    <= mem[midx(mem_addr)];
        last_rd_addr <= mem_addr;
        last_rd_be   <= mem_be;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic wb, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = {31'h7FFF_FFFF, wb};
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk("R8", "req_ready while busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic sweep(input int w, input logic [1:0] sz, input string rq);
    int ub, nbits, lat, idx, wpos;
    logic [31:0] abase, bbase, alias_a, rd;
    logic [3:0] ebe;
    logic eb;
    ub    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    nbits = ub * 8;
    abase = (w == 0) ? 32'h2200_0000 : 32'h4200_0000;
    bbase = (w == 0) ? 32'h2000_0000 : 32'h4000_0000;
    for (int off = 0; off < 8; off += ub) begin
      ebe = (ub == 1) ? (4'b0001 << (off % 4)) : (ub == 2) ? (4'b0011 << (off % 4)) : 4'b1111;
      for (int b = 0; b < nbits; b++) begin
        alias_a = abase + 32'(off * 32) + 32'(b * 4);
        idx  = w * 32 + off / 4;
        wpos = (off % 4) * 8 + b;
        eb   = refm[idx][wpos];
        access(alias_a, sz, 1'b0, 1'b0, rd, lat);
        chk("R6", "read bit", rd, {31'd0, eb});
        chk("R8", "read latency", 32'(lat), 32'd3);
        chk("R2", "read address", last_rd_addr, bbase + 32'(off));
        chk(rq, "read lanes", {28'd0, last_rd_be}, {28'd0, ebe});
        access(alias_a, sz, 1'b1, ~eb, rd, lat);
        refm[idx][wpos] = ~eb;
        chk("R8", "write latency", 32'(lat), 32'd4);
        chk("R7", "word after write", mem[idx], refm[idx]);
        chk("R7", "write lanes", {28'd0, last_wr_be}, {28'd0, ebe});
        chk("R2", "write address", last_wr_addr, bbase + 32'(off));
        access(alias_a, sz, 1'b0, 1'b0, rd, lat);
        chk(rq, "readback", rd, {31'd0, ~eb});
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R8 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    logic [31:0] miss_list [7];
    miss_list = '{32'h21FF_FFFC, 32'h2400_0000, 32'h2000_0010, 32'h41FF_FFFF,
                  32'h4400_0000, 32'h0000_0000, 32'h6200_0000};
    for (int i = 0; i < 64; i++) refm[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    req_addr = 32'h2200_0000;
    #1;
    chk("R9", "mem_valid after reset", {31'd0, mem_valid}, 32'd0);
    chk("R9", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R9", "idle ready after reset", {31'd0, req_ready}, 32'd1);

    // R1: addresses outside both windows are not claimed
    foreach (miss_list[k]) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = miss_list[k]; req_size = 2'd2; req_write = 1'b1;
      #1;
      chk("R1", "miss flag", {31'd0, req_miss}, 32'd1);
      chk("R1", "miss not ready", {31'd0, req_ready}, 32'd0);
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R1", "no memory request on miss", {31'd0, mem_valid}, 32'd0);
      end
      req_valid = 1'b0;
    end

    // R1, R2, R3, R5: top edges of each window
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h23FF_FFFC; req_size = 2'd0; #1;
    chk("R1", "upper edge of window 0 hits", {30'd0, req_miss, req_ready}, 32'd1);
    req_valid = 1'b0;
    access(32'h23FF_FFFC, 2'd0, 1'b0, 1'b0, rd, lat);
    chk("R2", "edge byte address", last_rd_addr, 32'h200F_FFFF);
    chk("R3", "edge byte lane", {28'd0, last_rd_be}, 32'h8);
    access(32'h43FF_FFFC, 2'd2, 1'b0, 1'b0, rd, lat);
    chk("R5", "edge word address", last_rd_addr, 32'h400F_FFFC);
    chk("R5", "edge word lanes", {28'd0, last_rd_be}, 32'hF);
    chk("R6", "upper bits zero", rd & 32'hFFFF_FFFE, 32'd0);

    for (int w = 0; w < 2; w++) begin
      sweep(w, 2'd0, "R3");
      sweep(w, 2'd1, "R4");
      sweep(w, 2'd2, "R5");
      sweep(w, 2'd3, "R5");
    end

    // R10: stalled memory handshakes
    stall_en = 1'b1;
    for (int b = 0; b < 8; b++) begin
      logic eb;
      eb = refm[33][8 + b];
      access(32'h4200_0000 + 32'd160 + 32'(b * 4), 2'd0, 1'b1, ~eb, rd, lat);
      refm[33][8 + b] = ~eb;
      chk("R10", "stalled write word", mem[33], refm[33]);
      access(32'h4200_0000 + 32'd160 + 32'(b * 4), 2'd0, 1'b0, 1'b0, rd, lat);
      chk("R10", "stalled readback", rd, {31'd0, ~eb});
    end
    stall_en = 1'b0;

    // R9: reset in the middle of an access
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2200_0004; req_size = 2'd2; req_write = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "mem_valid in reset", {31'd0, mem_valid}, 32'd0);
    chk("R9", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) refm[i] = pat(i);
    #1;
    chk("R9", "idle after mid-access reset", {31'd0, req_ready}, 32'd1);
    access(32'h2200_0004, 2'd2, 1'b0, 1'b0, rd, lat);
    chk("R9", "fresh read after reset", rd, {31'd0, refm[0][1]});
    chk("R9", "no stray response", {31'd0, rsp_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule